// File: doc/BRIEF.md
# Drive Status and Interrupt Unit

This block builds the eight-bit status byte that a disk drive presents to its host and drives the host interrupt line. It takes live condition flags from the drive core (ready, write fault, seek settled, data request, corrected data, index) and an error event. From these it produces one status byte. A strobed status read and an unstrobed alternate-status read both return this byte. An alternate-status read needs no strobe, because it has no side effect.

A small state machine owns the busy flag. Its states are ST_HOLD, ST_BUSY, ST_ARM and ST_IDLE. The machine enters ST_HOLD on power-on reset or while the software reset level is high. It moves ST_HOLD→ST_BUSY when software reset is released, and ST_BUSY→ST_IDLE on the core's done pulse. A busy request moves it ST_IDLE→ST_ARM. After a programmed delay it moves ST_ARM→ST_BUSY, or goes ST_IDLE→ST_BUSY directly when the delay is one. From any state, software reset returns it to ST_HOLD. After an error the ready, write-fault and seek bits are frozen until the host reads status. A pending interrupt is acknowledged only by the strobed read.

Top module: `drive_status_unit`

## Requirements
- R1: When not busy and not standing in, status_byte bits 7..0 are {0, ready, write fault, seek settled, data request, corrected, index, error}. Unfrozen bits follow the live inputs in the same cycle.
- R2: While rst_n is low or srst is high, and in the cycles after srst falls until a core_done pulse is sampled, status_byte reads 80h. Only bit 7 is set, and all other bits are masked.
- R3: A busy_req sampled in ST_IDLE makes status bit 7 read 1 from the ARM_CYC-th rising edge, counting the sampling edge as the first. Before that edge bit 7 reads 0. A busy_req sampled in any other state is ignored.
- R4: A core_done sampled in ST_BUSY clears bit 7 after that edge. A core_done sampled in other states has no effect.
- R5: Bit 0 (error) is set by a sampled core_err. It is cleared by a busy_req that is accepted in ST_IDLE. If both occur in the same cycle, core_err wins.
- R6: A sampled core_err captures the live ready, write-fault and seek values into bits 6, 5 and 4 and holds them. The hold lasts until a sampled stat_rd without core_err. After that the three bits follow the live inputs again.
- R7: A sampled core_irq makes the interrupt pending. Only a sampled stat_rd clears it. Reading the byte without the strobe leaves it pending.
- R8: If core_irq and stat_rd are sampled in the same cycle, the interrupt stays pending.
- R9: intrq_oe is 1 exactly when irq_en_n is 0 and drv_sel is 1. intrq equals the pending flag while intrq_oe is 1 and is 0 otherwise.
- R10: While stand_in is 1, status_byte reads 00h whatever the state.
- R11: A sampled srst clears the pending interrupt, the error bit and the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| srst | input | 1 | Software reset level |
| stat_rd | input | 1 | Strobed status read (acknowledges the interrupt) |
| core_ready | input | 1 | Live drive-ready condition |
| core_wfault | input | 1 | Live write-fault condition |
| core_seek_ok | input | 1 | Live seek-settled condition |
| core_drq | input | 1 | Live data-request condition |
| core_corr | input | 1 | Corrected-data condition |
| core_index | input | 1 | Index condition |
| core_err | input | 1 | Error event pulse |
| core_irq | input | 1 | Interrupt request pulse |
| busy_req | input | 1 | Request to raise busy (command start or block end) |
| core_done | input | 1 | Pulse ending the busy period |
| irq_en_n | input | 1 | Interrupt disable bit, active high |
| drv_sel | input | 1 | This drive is selected |
| stand_in | input | 1 | Answer for an absent peer drive |
| status_byte | output | 8 | Status / alternate status byte |
| intrq | output | 1 | Interrupt value |
| intrq_oe | output | 1 | Interrupt driver enable |

## Verification
Bits that follow live inputs, the stand-in zero and the interrupt enable change in the same cycle as their inputs. Pending, error, freeze and the return to idle change right after the rising edge that samples their cause. The busy bit after a request appears only at the ARM_CYC-th edge. The bench changes inputs just after each rising edge and compares every output on the falling edge against a behavioural model that it advances on the rising edge. Each result is therefore judged at the first half-cycle in which it is due, including the edge of the busy delay.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
    localparam int unsigned B_BSY = 7;
    localparam int unsigned B_RDY = 6;
    localparam int unsigned B_WF  = 5;
    localparam int unsigned B_SK  = 4;
    localparam int unsigned B_DRQ = 3;
    localparam int unsigned B_COR = 2;
    localparam int unsigned B_IDX = 1;
    localparam int unsigned B_ERR = 0;
    localparam int unsigned STAT_W = 8;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_BUSY = 2'd1,
        ST_IDLE = 2'd2,
        ST_ARM  = 2'd3
    } bsy_st_e;

    typedef struct packed {
        logic rdy;
        logic wf;
        logic sk;
    } cond_t;
endpackage

// File: rtl/dsu_busy_fsm.sv
module dsu_busy_fsm
    import dsu_pkg::*;
#(
    parameter int unsigned ARM_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic busy_req,
    input  logic core_done,
    output logic bsy,
    output logic take
);
    localparam int unsigned CNT_W    = (ARM_CYC < 2) ? 1 : $clog2(ARM_CYC);
    localparam int unsigned ARM_LOAD = (ARM_CYC >= 2) ? ARM_CYC - 2 : 0;

    bsy_st_e            st, st_nx;
    logic [CNT_W-1:0]   cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (srst) begin
            st_nx = ST_HOLD;
        end else begin
            unique case (st)
                ST_HOLD: st_nx = ST_BUSY;
                ST_BUSY: if (core_done) st_nx = ST_IDLE;
                ST_IDLE: begin
                    if (busy_req) begin
                        if (ARM_CYC < 2) begin
                            st_nx = ST_BUSY;
                        end else begin
                            st_nx  = ST_ARM;
                            cnt_nx = CNT_W'(ARM_LOAD);
                        end
                    end
                end
                ST_ARM: begin
                    if (cnt == '0) st_nx = ST_BUSY;
                    else           cnt_nx = cnt - 1'b1;
                end
                default: st_nx = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        bsy  = (st == ST_HOLD) || (st == ST_BUSY);
        take = (st == ST_IDLE) && busy_req && !srst;
    end

    p_srst_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> bsy);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !busy_req && !srst) |=> !bsy);
    p_req_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && busy_req && !core_done && !srst) |=> bsy);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && core_done && !srst) |=> !bsy);
endmodule

// File: rtl/dsu_cond_hold.sv
module dsu_cond_hold
    import dsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic err_evt,
    input  logic stat_rd,
    input  logic take,
    input  logic live_rdy,
    input  logic live_wf,
    input  logic live_sk,
    output logic rdy_o,
    output logic wf_o,
    output logic sk_o,
    output logic err_o
);
    logic  frozen;
    logic  err_q;
    cond_t held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen <= 1'b0;
            err_q  <= 1'b0;
            held   <= '0;
        end else if (srst) begin
            frozen <= 1'b0;
            err_q  <= 1'b0;
        end else if (err_evt) begin
            frozen   <= 1'b1;
            err_q    <= 1'b1;
            held.rdy <= live_rdy;
            held.wf  <= live_wf;
            held.sk  <= live_sk;
        end else begin
            if (stat_rd) frozen <= 1'b0;
            if (take)    err_q  <= 1'b0;
        end
    end

    always_comb begin
        rdy_o = frozen ? held.rdy : live_rdy;
        wf_o  = frozen ? held.wf  : live_wf;
        sk_o  = frozen ? held.sk  : live_sk;
        err_o = err_q;
    end

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !err_evt && !stat_rd && !srst) |=> (frozen && $stable(held)));
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && !srst) |=> err_q);
    p_err_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !err_evt && !srst) |=> !err_q);
    p_srst_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!frozen && !err_q));
endmodule

// File: rtl/dsu_irq_ctl.sv
module dsu_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic irq_req,
    input  logic stat_rd,
    input  logic irq_en_n,
    input  logic drv_sel,
    output logic intrq,
    output logic intrq_oe
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend <= 1'b0;
        else if (srst)    pend <= 1'b0;
        else if (irq_req) pend <= 1'b1;
        else if (stat_rd) pend <= 1'b0;
    end

    always_comb begin
        intrq_oe = !irq_en_n && drv_sel;
        intrq    = pend && intrq_oe;
    end

    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !irq_req && !srst) |=> !pend);
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !stat_rd && !srst) |=> pend);
    p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && stat_rd && !srst) |=> pend);
    p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !pend);
endmodule

// File: rtl/drive_status_unit.sv
module drive_status_unit
    import dsu_pkg::*;
#(
    parameter int unsigned ARM_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              stat_rd,
    input  logic              core_ready,
    input  logic              core_wfault,
    input  logic              core_seek_ok,
    input  logic              core_drq,
    input  logic              core_corr,
    input  logic              core_index,
    input  logic              core_err,
    input  logic              core_irq,
    input  logic              busy_req,
    input  logic              core_done,
    input  logic              irq_en_n,
    input  logic              drv_sel,
    input  logic              stand_in,
    output logic [STAT_W-1:0] status_byte,
    output logic              intrq,
    output logic              intrq_oe
);
    logic bsy, take;
    logic rdy_v, wf_v, sk_v, err_v;

    dsu_busy_fsm #(.ARM_CYC(ARM_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .busy_req  (busy_req),
        .core_done (core_done),
        .bsy       (bsy),
        .take      (take)
    );

    dsu_cond_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .err_evt  (core_err),
        .stat_rd  (stat_rd),
        .take     (take),
        .live_rdy (core_ready),
        .live_wf  (core_wfault),
        .live_sk  (core_seek_ok),
        .rdy_o    (rdy_v),
        .wf_o     (wf_v),
        .sk_o     (sk_v),
        .err_o    (err_v)
    );

    dsu_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .irq_req  (core_irq),
        .stat_rd  (stat_rd),
        .irq_en_n (irq_en_n),
        .drv_sel  (drv_sel),
        .intrq    (intrq),
        .intrq_oe (intrq_oe)
    );

    always_comb begin
        status_byte = '0;
        if (!stand_in) begin
            if (bsy) begin
                status_byte[B_BSY] = 1'b1;
            end else begin
                status_byte[B_RDY] = rdy_v;
                status_byte[B_WF]  = wf_v;
                status_byte[B_SK]  = sk_v;
                status_byte[B_DRQ] = core_drq;
                status_byte[B_COR] = core_corr;
                status_byte[B_IDX] = core_index;
                status_byte[B_ERR] = err_v;
            end
        end
    end

    p_err_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_err && !srst && !bsy && !busy_req && !core_done) |=> (stand_in || status_byte[B_ERR] || status_byte[B_BSY]));
endmodule

// File: tb/drive_status_unit_bench.sv
module drive_status_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ARM = 3;

    logic clk = 1'b0;
    logic rst_n, srst, stat_rd, core_ready, core_wfault, core_seek_ok;
    logic core_drq, core_corr, core_index, core_err, core_irq;
    logic busy_req, core_done, irq_en_n, drv_sel, stand_in;
    logic [7:0] status_byte;
    logic intrq, intrq_oe;

    int checks = 0;
    int fails  = 0;
    string cur = "R2";
    bit done_flag = 0;

    // behavioural reference state
    int m_mode = 0;   // 0 hold, 1 busy, 2 idle, 3 arming
    int m_left = 0;
    bit m_err = 0, m_frz = 0, m_pend = 0;
    bit h_rdy = 0, h_wf = 0, h_sk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drive_status_unit #(.ARM_CYC(ARM)) u_drive_status_unit (
        .clk(clk), .rst_n(rst_n), .srst(srst), .stat_rd(stat_rd),
        .core_ready(core_ready), .core_wfault(core_wfault), .core_seek_ok(core_seek_ok),
        .core_drq(core_drq), .core_corr(core_corr), .core_index(core_index),
        .core_err(core_err), .core_irq(core_irq), .busy_req(busy_req),
        .core_done(core_done), .irq_en_n(irq_en_n), .drv_sel(drv_sel),
        .stand_in(stand_in), .status_byte(status_byte), .intrq(intrq), .intrq_oe(intrq_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_err = 0; m_frz = 0; m_pend = 0;
            h_rdy = 0; h_wf = 0; h_sk = 0;
        end else if (srst) begin
            m_mode = 0; m_err = 0; m_frz = 0; m_pend = 0;
        end else begin
            bit accepted;
            accepted = (m_mode == 2) && busy_req;
            if (core_err) begin
                m_err = 1; m_frz = 1;
                h_rdy = core_ready; h_wf = core_wfault; h_sk = core_seek_ok;
            end else begin
                if (stat_rd) m_frz = 0;
                if (accepted) m_err = 0;
            end
            if (core_irq) m_pend = 1;
            else if (stat_rd) m_pend = 0;
            case (m_mode)
                0: m_mode = 1;
                1: if (core_done) m_mode = 2;
                2: if (busy_req) begin
                       if (ARM == 1) m_mode = 1;
                       else begin m_mode = 3; m_left = ARM - 1; end
                   end
                default: begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_mode = 1;
                end
            endcase
        end
    end

    function automatic logic [7:0] exp_byte();
        logic [7:0] b;
        if (stand_in) return 8'h00;
        if (m_mode == 0 || m_mode == 1) return 8'h80;
        b = {1'b0, m_frz ? h_rdy : core_ready, m_frz ? h_wf : core_wfault,
             m_frz ? h_sk : core_seek_ok, core_drq, core_corr, core_index, m_err};
        return b;
    endfunction

    always @(negedge clk) begin
        if (!done_flag) begin
            logic [7:0] eb;
            logic eoe, ei;
            eb  = exp_byte();
            eoe = !irq_en_n && drv_sel;
            ei  = m_pend && eoe;
            checks++;
            if (status_byte !== eb) begin
                fails++;
                $display("FAIL %s status_byte act=%h exp=%h t=%0t", cur, status_byte, eb, $time);
            end
            checks++;
            if (intrq_oe !== eoe || intrq !== ei) begin
                fails++;
                $display("FAIL R9/%s intrq act=%b/%b exp=%b/%b t=%0t", cur, intrq, intrq_oe, ei, eoe, $time);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; srst = 0; stat_rd = 0; core_ready = 0; core_wfault = 0;
        core_seek_ok = 0; core_drq = 0; core_corr = 0; core_index = 0;
        core_err = 0; core_irq = 0; busy_req = 0; core_done = 0;
        irq_en_n = 1; drv_sel = 0; stand_in = 0;
        cur = "R2";
        step(3);
        rst_n = 1;
        core_ready = 1;
        step(3);
        core_done = 1; step(1); core_done = 0;

        cur = "R1";
        for (int k = 0; k < 12; k++) begin
            {core_ready, core_wfault, core_seek_ok, core_drq, core_corr, core_index} = 6'(k * 11 + 5);
            step(1);
        end
        core_ready = 1; core_wfault = 0; core_seek_ok = 1; core_drq = 0;
        core_corr = 0; core_index = 0;

        cur = "R3";
        busy_req = 1; step(1); busy_req = 0;
        step(4);
        busy_req = 1; step(1); busy_req = 0;
        step(2);

        cur = "R4";
        core_done = 1; step(1); core_done = 0;
        step(2);
        core_done = 1; step(1); core_done = 0;
        step(1);

        cur = "R5";
        core_err = 1; step(1); core_err = 0;
        step(2);
        busy_req = 1; step(1); busy_req = 0;
        step(ARM + 1);
        core_done = 1; step(1); core_done = 0;
        step(1);
        core_err = 1; busy_req = 1; step(1); core_err = 0; busy_req = 0;
        step(ARM + 1);
        core_done = 1; step(1); core_done = 0;
        stat_rd = 1; step(1); stat_rd = 0;
        step(1);

        cur = "R6";
        core_ready = 1; core_wfault = 0; core_seek_ok = 1;
        core_err = 1; step(1); core_err = 0;
        core_ready = 0; core_wfault = 1; core_seek_ok = 0;
        step(3);
        stat_rd = 1; step(1); stat_rd = 0;
        step(2);
        core_ready = 1; core_wfault = 0; core_seek_ok = 1;
        step(1);

        cur = "R7";
        irq_en_n = 0; drv_sel = 1;
        core_irq = 1; step(1); core_irq = 0;
        step(3);
        stat_rd = 1; step(1); stat_rd = 0;
        step(2);

        cur = "R8";
        core_irq = 1; stat_rd = 1; step(1); core_irq = 0; stat_rd = 0;
        step(2);
        stat_rd = 1; step(1); stat_rd = 0;
        step(1);

        cur = "R9";
        core_irq = 1; step(1); core_irq = 0;
        for (int k = 0; k < 4; k++) begin
            {irq_en_n, drv_sel} = 2'(k);
            step(2);
        end
        irq_en_n = 0; drv_sel = 1;
        step(1);

        cur = "R10";
        stand_in = 1; step(2);
        srst = 1; step(2); srst = 0;
        step(2);
        stand_in = 0; step(1);
        core_done = 1; step(1); core_done = 0;
        step(1);

        cur = "R11";
        core_irq = 1; core_err = 1; step(1); core_irq = 0; core_err = 0;
        core_ready = 0; step(2);
        srst = 1; step(3); srst = 0;
        step(2);
        core_done = 1; step(1); core_done = 0;
        core_ready = 1;
        step(3);

        finish_run();
    end
endmodule